// File: doc/BRIEF.md
# Supervisor Restore Fault Checker

This block screens a privileged extended-state restore request before any architectural state is touched. The request carries the privilege level, the address of the save area, the feature-present and OS-enable flags, the task-switched flag, the lock-prefix indication, the enable mask, the save-area header fields (compaction vector, state vector, reserved header bytes) and the control/status value that the restore would load. The block answers with one prioritized fault code and, for general-protection faults, a one-hot cause.

The checker is a small three-state machine. `ST_IDLE` waits with `req_ready` high; a request (`req_valid`) in `ST_IDLE` is captured and takes the transition IDLE->EVAL. In `ST_EVAL` the captured fields are evaluated and the result is registered (transition EVAL->REPORT). In `ST_REPORT` `rsp_valid` is high for one cycle with the result, and the machine returns REPORT->IDLE. While the machine is in EVAL or REPORT, `req_ready` is low and `req_valid` is ignored.

Top module: `sv_restore_guard`

## Requirements
- R1: Fault code 1 (undefined opcode) is reported when `has_save` is 0, when `has_sup_save` is 0, when `os_save_en` is 0, or when `lock_pfx` is 1.
- R2: Fault code 2 (device not available) is reported when `task_sw` is 1 and no R1 condition holds.
- R3: Priority is code 1 over code 2 over code 3 (general protection); code 0 means no fault.
- R4: `cpl` other than 0 gives code 3 with cause bit 0.
- R5: An area address whose low 6 bits are not all zero gives code 3 with cause bit 1.
- R6: Bit 63 of the compaction vector being 0 gives code 3 with cause bit 2.
- R7: Any compaction-vector bit in 62:0 set while the same enable-mask bit is clear gives code 3 with cause bit 3.
- R8: Any state-vector bit in 62:0 set while the same compaction-vector bit is clear gives code 3 with cause bit 4.
- R9: Any set bit in the 48 reserved header bytes gives code 3 with cause bit 5.
- R10: A control/status value with any bit of the reserved mask (default bits 31:16) set gives code 3 with cause bit 6.
- R11: The cause output is one-hot, showing the lowest-numbered active cause when several hold, and is zero unless a code-3 response is being reported.
- R12: A request is taken only when `req_ready` is 1; `rsp_valid` rises two clock cycles after acceptance and lasts one cycle; inputs and requests presented while busy have no effect.
- R13: After reset the block is idle: `req_ready` 1, `rsp_valid` 0, fault 0, cause 0; a clean request yields fault 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and accepting |
| cpl | input | 2 | Current privilege level |
| area_addr | input | ADDR_W | Save-area address |
| has_save | input | 1 | Save feature present |
| has_sup_save | input | 1 | Supervisor save sub-feature present |
| os_save_en | input | 1 | OS has enabled extended save |
| task_sw | input | 1 | Task-switched control flag |
| lock_pfx | input | 1 | Lock prefix on the request |
| en_mask | input | MASK_W | Enabled-component mask |
| hdr_comp | input | MASK_W | Header compaction vector |
| hdr_state | input | MASK_W | Header state vector |
| hdr_resv | input | 8*HDR_RSV_BYTES | Reserved header bytes |
| ctl_val | input | CTL_W | Control/status value to be loaded |
| rsp_valid | output | 1 | Result strobe |
| rsp_fault | output | 2 | 0 none, 1 undefined opcode, 2 device not available, 3 general protection |
| rsp_gp_cause | output | 7 | One-hot general-protection cause |

## Verification
A wrong state in the machine shows at the ports within one or two cycles: a stuck EVAL or REPORT leaves `req_ready` low or makes `rsp_valid` last more than one cycle, and a skipped EVAL moves the strobe one cycle early. A wrong capture register or a wrong cause term shows on the very next strobe as a fault code or cause bit that differs from the table entry, so each cause is driven alone and in combinations that test the priority order.

// File: rtl/rg_pkg.sv
package rg_pkg;
    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_UD   = 2'd1,
        FLT_NM   = 2'd2,
        FLT_GP   = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EVAL,
        ST_REPORT
    } state_e;

    localparam int GP_N        = 7;
    localparam int GP_PRIV     = 0;
    localparam int GP_ALIGN    = 1;
    localparam int GP_FMT      = 2;
    localparam int GP_COMP_EN  = 3;
    localparam int GP_STATE    = 4;
    localparam int GP_HDR      = 5;
    localparam int GP_CTL      = 6;
endpackage

// File: rtl/rg_cause_eval.sv
module rg_cause_eval
    import rg_pkg::*;
#(
    parameter int MASK_W = 64,
    parameter int ALIGN_LSB = 6,
    parameter int RSV_W = 384,
    parameter int CTL_W = 32,
    parameter logic [CTL_W-1:0] CTL_RSVD_MASK = 32'hFFFF_0000
) (
    input  logic [1:0]           cpl_i,
    input  logic [ALIGN_LSB-1:0] addr_lo_i,
    input  logic                 has_save_i,
    input  logic                 has_sup_i,
    input  logic                 os_en_i,
    input  logic                 task_sw_i,
    input  logic                 lock_i,
    input  logic [MASK_W-1:0]    en_i,
    input  logic [MASK_W-1:0]    comp_i,
    input  logic [MASK_W-1:0]    state_i,
    input  logic [RSV_W-1:0]     resv_i,
    input  logic [CTL_W-1:0]     ctl_i,
    output logic                 ud_o,
    output logic                 nm_o,
    output logic [GP_N-1:0]      gp_o
);
    localparam logic [MASK_W-1:0] TOP_BIT = {1'b1, {(MASK_W-1){1'b0}}};

    always_comb begin
        ud_o = !has_save_i || !has_sup_i || !os_en_i || lock_i;
        nm_o = task_sw_i;
        gp_o = '0;
        gp_o[GP_PRIV]    = (cpl_i != 2'd0);
        gp_o[GP_ALIGN]   = |addr_lo_i;
        gp_o[GP_FMT]     = !comp_i[MASK_W-1];
        gp_o[GP_COMP_EN] = |(comp_i & ~(en_i | TOP_BIT));
        gp_o[GP_STATE]   = |(state_i & ~(comp_i | TOP_BIT));
        gp_o[GP_HDR]     = |resv_i;
        gp_o[GP_CTL]     = |(ctl_i & CTL_RSVD_MASK);
    end
endmodule

// File: rtl/rg_prio.sv
module rg_prio
    import rg_pkg::*;
(
    input  logic            ud_i,
    input  logic            nm_i,
    input  logic [GP_N-1:0] gp_i,
    output fault_e          fault_o,
    output logic [GP_N-1:0] cause_o
);
    logic [GP_N-1:0] lowest;
    assign lowest = gp_i & (~gp_i + 1'b1);

    always_comb begin
        fault_o = FLT_NONE;
        cause_o = '0;
        if (ud_i) begin
            fault_o = FLT_UD;
        end else if (nm_i) begin
            fault_o = FLT_NM;
        end else if (|gp_i) begin
            fault_o = FLT_GP;
            cause_o = lowest;
        end
    end
endmodule

// File: rtl/sv_restore_guard.sv
module sv_restore_guard
    import rg_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int MASK_W = 64,
    parameter int ALIGN_BYTES = 64,
    parameter int HDR_RSV_BYTES = 48,
    parameter int CTL_W = 32,
    parameter logic [CTL_W-1:0] CTL_RSVD_MASK = 32'hFFFF_0000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [1:0]                 cpl,
    input  logic [ADDR_W-1:0]          area_addr,
    input  logic                       has_save,
    input  logic                       has_sup_save,
    input  logic                       os_save_en,
    input  logic                       task_sw,
    input  logic                       lock_pfx,
    input  logic [MASK_W-1:0]          en_mask,
    input  logic [MASK_W-1:0]          hdr_comp,
    input  logic [MASK_W-1:0]          hdr_state,
    input  logic [8*HDR_RSV_BYTES-1:0] hdr_resv,
    input  logic [CTL_W-1:0]           ctl_val,
    output logic                       rsp_valid,
    output logic [1:0]                 rsp_fault,
    output logic [6:0]                 rsp_gp_cause
);
    localparam int ALIGN_LSB = $clog2(ALIGN_BYTES);
    localparam int RSV_W     = 8 * HDR_RSV_BYTES;

    state_e state_q, state_d;

    logic [1:0]           cpl_q;
    logic [ALIGN_LSB-1:0] addr_lo_q;
    logic                 save_q, sup_q, osen_q, ts_q, lock_q;
    logic [MASK_W-1:0]    en_q, comp_q, st_q;
    logic [RSV_W-1:0]     resv_q;
    logic [CTL_W-1:0]     ctl_q;

    logic                 unused_addr_hi;
    assign unused_addr_hi = ^area_addr[ADDR_W-1:ALIGN_LSB];

    logic                 ud, nm;
    logic [GP_N-1:0]      gp_vec, cause;
    fault_e               fault;

    assign req_ready = (state_q == ST_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_EVAL;
            ST_EVAL:   state_d = ST_REPORT;
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // request capture, only on acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpl_q <= '0; addr_lo_q <= '0;
            save_q <= 1'b0; sup_q <= 1'b0; osen_q <= 1'b0;
            ts_q <= 1'b0; lock_q <= 1'b0;
            en_q <= '0; comp_q <= '0; st_q <= '0;
            resv_q <= '0; ctl_q <= '0;
        end else if (req_valid && req_ready) begin
            cpl_q     <= cpl;
            addr_lo_q <= area_addr[ALIGN_LSB-1:0];
            save_q    <= has_save;
            sup_q     <= has_sup_save;
            osen_q    <= os_save_en;
            ts_q      <= task_sw;
            lock_q    <= lock_pfx;
            en_q      <= en_mask;
            comp_q    <= hdr_comp;
            st_q      <= hdr_state;
            resv_q    <= hdr_resv;
            ctl_q     <= ctl_val;
        end
    end

    rg_cause_eval #(
        .MASK_W(MASK_W), .ALIGN_LSB(ALIGN_LSB), .RSV_W(RSV_W),
        .CTL_W(CTL_W), .CTL_RSVD_MASK(CTL_RSVD_MASK)
    ) u_eval (
        .cpl_i(cpl_q), .addr_lo_i(addr_lo_q),
        .has_save_i(save_q), .has_sup_i(sup_q), .os_en_i(osen_q),
        .task_sw_i(ts_q), .lock_i(lock_q),
        .en_i(en_q), .comp_i(comp_q), .state_i(st_q),
        .resv_i(resv_q), .ctl_i(ctl_q),
        .ud_o(ud), .nm_o(nm), .gp_o(gp_vec)
    );

    rg_prio u_prio (
        .ud_i(ud), .nm_i(nm), .gp_i(gp_vec),
        .fault_o(fault), .cause_o(cause)
    );

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_fault    <= FLT_NONE;
            rsp_gp_cause <= '0;
        end else if (state_q == ST_EVAL) begin
            rsp_valid    <= 1'b1;
            rsp_fault    <= fault;
            rsp_gp_cause <= cause;
        end else begin
            rsp_valid    <= 1'b0;
            rsp_fault    <= FLT_NONE;
            rsp_gp_cause <= '0;
        end
    end

    // R12
    resp_onecycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R12
    accept_to_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> ##2 rsp_valid);

    // R12
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R11
    cause_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_gp_cause));

    // R11
    cause_gp_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_gp_cause != '0) |-> (rsp_valid && rsp_fault == FLT_GP));

    // R11
    gp_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == FLT_GP) |-> (rsp_gp_cause != '0));
endmodule

// File: tb/sim_sv_restore_guard.sv
`timescale 1ns/1ps
module sim_sv_restore_guard;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [1:0]   cpl = '0;
    logic [63:0]  area_addr = '0;
    logic         has_save = 1'b1, has_sup_save = 1'b1, os_save_en = 1'b1;
    logic         task_sw = 1'b0, lock_pfx = 1'b0;
    logic [63:0]  en_mask = '0, hdr_comp = '0, hdr_state = '0;
    logic [383:0] hdr_resv = '0;
    logic [31:0]  ctl_val = '0;
    logic         rsp_valid;
    logic [1:0]   rsp_fault;
    logic [6:0]   rsp_gp_cause;

    int checks = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    sv_restore_guard u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .cpl(cpl), .area_addr(area_addr), .has_save(has_save),
        .has_sup_save(has_sup_save), .os_save_en(os_save_en),
        .task_sw(task_sw), .lock_pfx(lock_pfx), .en_mask(en_mask),
        .hdr_comp(hdr_comp), .hdr_state(hdr_state), .hdr_resv(hdr_resv),
        .ctl_val(ctl_val), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_gp_cause(rsp_gp_cause)
    );

    typedef struct packed {
        logic       save;
        logic       sup;
        logic       osen;
        logic       ts;
        logic       lock;
        logic [1:0] cpl;
        logic [5:0] aoff;
        logic       c63clr;
        logic       cen;
        logic       sbad;
        logic       hdr;
        logic       ctl;
        logic [1:0] efault;
        logic [6:0] ecause;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t TBL [NV] = '{
        '{1,1,1,0,0,2'd0,6'd0, 0,0,0,0,0, 2'd0,7'b0000000}, // R13 clean
        '{0,1,1,0,0,2'd0,6'd0, 0,0,0,0,0, 2'd1,7'b0000000}, // R1 no save
        '{1,0,1,0,0,2'd0,6'd0, 0,0,0,0,0, 2'd1,7'b0000000}, // R1 no sup
        '{1,1,0,0,0,2'd0,6'd0, 0,0,0,0,0, 2'd1,7'b0000000}, // R1 os off
        '{1,1,1,0,1,2'd0,6'd0, 0,0,0,0,0, 2'd1,7'b0000000}, // R1 lock
        '{1,1,1,1,0,2'd0,6'd0, 0,0,0,0,0, 2'd2,7'b0000000}, // R2 ts
        '{1,1,1,1,1,2'd3,6'd0, 0,0,0,0,0, 2'd1,7'b0000000}, // R3 ud wins
        '{1,1,1,1,0,2'd1,6'd8, 0,0,0,0,1, 2'd2,7'b0000000}, // R3 nm over gp
        '{1,1,1,0,0,2'd3,6'd0, 0,0,0,0,0, 2'd3,7'b0000001}, // R4
        '{1,1,1,0,0,2'd0,6'd8, 0,0,0,0,0, 2'd3,7'b0000010}, // R5
        '{1,1,1,0,0,2'd0,6'd0, 1,0,0,0,0, 2'd3,7'b0000100}, // R6
        '{1,1,1,0,0,2'd0,6'd0, 0,1,0,0,0, 2'd3,7'b0001000}, // R7
        '{1,1,1,0,0,2'd0,6'd0, 0,0,1,0,0, 2'd3,7'b0010000}, // R8
        '{1,1,1,0,0,2'd0,6'd0, 0,0,0,1,0, 2'd3,7'b0100000}, // R9
        '{1,1,1,0,0,2'd0,6'd0, 0,0,0,0,1, 2'd3,7'b1000000}, // R10
        '{1,1,1,0,0,2'd0,6'd32,0,0,1,0,1, 2'd3,7'b0000010}, // R11 lowest
        '{1,1,1,0,0,2'd0,6'd0, 0,1,0,1,0, 2'd3,7'b0001000}, // R11 lowest
        '{1,1,1,0,0,2'd1,6'd1, 1,1,1,1,1, 2'd3,7'b0000001}  // R11 all gp
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load(input vec_t v);
        has_save     = v.save;
        has_sup_save = v.sup;
        os_save_en   = v.osen;
        task_sw      = v.ts;
        lock_pfx     = v.lock;
        cpl          = v.cpl;
        area_addr    = 64'h0000_7FFF_1234_0000 | 64'(v.aoff);
        en_mask      = 64'h0000_0000_0000_00FF;
        hdr_comp     = (v.c63clr ? 64'h0 : 64'h8000_0000_0000_0000) | 64'h3
                       | (v.cen ? 64'h200 : 64'h0);
        hdr_state    = 64'h3 | (v.sbad ? 64'h20 : 64'h0);
        hdr_resv     = '0;
        if (v.hdr) hdr_resv[200] = 1'b1;
        ctl_val      = 32'h0000_1F80 | (v.ctl ? 32'h0001_0000 : 32'h0);
    endtask

    task automatic run(input vec_t v, input int idx);
        @(negedge clk);
        load(v);
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid == 1'b0, "R12 no early strobe", rsp_valid, 0);
        @(posedge clk);
        @(negedge clk);
        chk(rsp_valid == 1'b1, "R12 strobe", rsp_valid, 1);
        chk(rsp_fault == v.efault, $sformatf("R3 fault vec%0d", idx), rsp_fault, v.efault);
        chk(rsp_gp_cause == v.ecause, $sformatf("R11 cause vec%0d", idx), rsp_gp_cause, v.ecause);
        @(posedge clk);
        @(negedge clk);
        chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R12 one cycle", rsp_valid, 0);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        load(TBL[0]);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R13 reset state
        chk(req_ready == 1'b1, "R13 ready", req_ready, 1);
        chk(rsp_valid == 1'b0, "R13 valid", rsp_valid, 0);
        chk(rsp_fault == 2'd0 && rsp_gp_cause == 7'd0, "R13 outputs", rsp_fault, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) run(TBL[i], i);

        // R12 busy: changed inputs and a new request while busy are ignored
        @(negedge clk);
        load(TBL[0]);
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(req_ready == 1'b0, "R12 busy not ready", req_ready, 0);
        load(TBL[4]);
        cpl = 2'd3;
        @(posedge clk);
        @(negedge clk);
        chk(rsp_valid == 1'b1 && rsp_fault == 2'd0, "R12 captured inputs kept", rsp_fault, 0);
        req_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R12 no second strobe", rsp_valid, 0);
        @(posedge clk);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R12 busy request dropped", rsp_valid, 0);
        @(posedge clk);
        @(negedge clk);
        chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R12 idle after drop", rsp_valid, 0);

        // R10 non-reserved control bits alone are clean
        begin
            vec_t v;
            v = TBL[0];
            @(negedge clk);
            load(v);
            ctl_val = 32'h0000_FFFF;
            req_valid = 1'b1;
            @(posedge clk);
            @(negedge clk);
            req_valid = 1'b0;
            @(posedge clk);
            @(negedge clk);
            chk(rsp_valid && rsp_fault == 2'd0, "R10 low bits legal", rsp_fault, 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule